// File: doc/BRIEF.md
# Single-Cell Battery Protection Controller

This block decides, for one rechargeable cell, whether the charge path and the discharge path may conduct. Its inputs are digital flags from analog comparators: where the cell voltage sits relative to its overcharge, overcharge-release, overdischarge, overdischarge-release and zero-volt levels, and where the sense-pin voltage sits relative to the charger-detect, three overcurrent and low-headroom levels. All flags are asynchronous and are synchronised inside the block. The block drives two enables, `chg_en` and `dsg_en`, and a `pwr_down` indicator.

Fault qualification time is not counted here. When a fault condition appears in the normal state, the controller asks an external delay timer to start, names the delay kind, and waits for a one-cycle completion pulse. If the condition vanishes first, it asks the timer to clear. Each fault state has its own release rule, and that rule depends on whether a charger or a load is present. A build parameter chooses between two zero-volt policies: inhibit charging of a dead cell, or force the charge path on when the charger voltage is high enough.

Top module: `cell_guard_ctrl`

## Requirements
- R1: After reset the controller is in the normal state with `chg_en`=1, `dsg_en`=1 and `pwr_down`=0.
- R2: In the normal state, `ovc_hi` held until a completion pulse for kind 1 (overcharge) clears `chg_en` and keeps `dsg_en` high.
- R3: The overcharge state returns to normal when `ocrel_lo`=1 with `chg_seen`=0, or when `oc1_hi`=1 with `ovc_hi`=0 (a load with the cell below the overcharge level).
- R4: While `chg_seen`=1 the overcharge state is held even with `ocrel_lo`=1. Release follows only after `chg_seen` returns to 0.
- R5: In the normal state, `ovd_lo` held until a completion pulse for kind 2 clears `dsg_en` and keeps `chg_en` high.
- R6: In overdischarge, `vm_small`=1 with no charger enters power-down (`pwr_down`=1). `chg_seen`=1 leaves power-down back to overdischarge.
- R7: Overdischarge returns to normal when `chg_seen`=1 and `ovd_lo`=0. Without a charger it needs `odrel_hi`=1.
- R8: Overcurrent kinds have the priority short (kind 5) > level 2 (kind 4) > level 1 (kind 3). The qualified one clears `dsg_en`. Release to normal happens when `oc1_hi`=0.
- R9: In the normal state (discharge enabled), `chg_seen` held until a completion pulse for kind 6 (uses the overcharge delay) clears `chg_en`. `chg_seen`=0 restores it.
- R10: A new candidate fault pulses `tmr_start` with its kind on `tmr_kind`. A candidate that vanishes pulses `tmr_clear`. `tmr_start` and `tmr_clear` never coincide. A completion pulse that does not match the pending kind has no effect.
- R11: With `ZV_CHARGE`=0, `chg_en` is 0 whenever `zv_lo`=1, and `zv_start` has no effect.
- R12: With `ZV_CHARGE`=1, `chg_en` is 1 whenever `zv_start`=1, including in abnormal-charge lockout.
- R13: Flags pass through `SYNC_STAGES` (default 2) flops. The zero-volt override reaches `chg_en` two edges after a flag change, and state-driven outputs follow one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovc_hi | input | 1 | Cell above overcharge level |
| ocrel_lo | input | 1 | Cell below overcharge release level |
| ovd_lo | input | 1 | Cell below overdischarge level |
| odrel_hi | input | 1 | Cell at or above overdischarge level plus hysteresis |
| chg_seen | input | 1 | Sense below charger-detect level |
| oc1_hi | input | 1 | Sense at or above overcurrent level 1 |
| oc2_hi | input | 1 | Sense at or above overcurrent level 2 |
| short_hi | input | 1 | Sense at or above short-circuit level |
| vm_small | input | 1 | Sense-to-supply difference small |
| zv_lo | input | 1 | Cell below zero-volt inhibit level |
| zv_start | input | 1 | Charger voltage at or above zero-volt start level |
| tmr_done | input | 1 | One-cycle delay completion pulse |
| tmr_start | output | 1 | Start request for the delay timer |
| tmr_clear | output | 1 | Clear request for the delay timer |
| tmr_kind | output | 3 | Delay kind: 1 overcharge, 2 overdischarge, 3 oc1, 4 oc2, 5 short, 6 abnormal charge |
| chg_en | output | 1 | Charge path enable |
| dsg_en | output | 1 | Discharge path enable |
| pwr_down | output | 1 | Power-down state indicator |

## Verification
The zero-volt overrides are due two edges after a flag changes. A state change is due three edges after the flag, plus the modelled timer delay when qualification is needed. The timer start goes out on the edge that follows the synchronised flag, and completion arrives one edge after the bench timer's count runs out. The bench drives inputs on the falling edge. Each check waits a margin longer than the worst-case path, and shorter than the next-shortest delay that could disturb the result. Latency itself is checked edge by edge on the zero-volt path.

// File: rtl/cgc_pkg.sv
package cgc_pkg;
   typedef enum logic [2:0] {
      ST_NORM   = 3'd0,
      ST_OVCHG  = 3'd1,
      ST_OVDIS  = 3'd2,
      ST_PDOWN  = 3'd3,
      ST_OVCUR  = 3'd4,
      ST_ABNCHG = 3'd5
   } cgc_state_e;

   typedef enum logic [2:0] {
      K_NONE  = 3'd0,
      K_OVC   = 3'd1,
      K_OVD   = 3'd2,
      K_OC1   = 3'd3,
      K_OC2   = 3'd4,
      K_SHORT = 3'd5,
      K_ABN   = 3'd6
   } cgc_kind_e;

   typedef struct packed {
      logic ovc_hi;
      logic ocrel_lo;
      logic ovd_lo;
      logic odrel_hi;
      logic chg_seen;
      logic oc1_hi;
      logic oc2_hi;
      logic short_hi;
      logic vm_small;
      logic zv_lo;
      logic zv_start;
   } cgc_flags_t;

   localparam int unsigned CGC_NFLAGS = $bits(cgc_flags_t);
endpackage

// File: rtl/cgc_sync.sv
module cgc_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cgc_sync needs at least two stages");
      end
      if (W < 1) begin : g_bad_width
         $error("cgc_sync needs a nonzero width");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cgc_fsm.sv
module cgc_fsm
   import cgc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  cgc_flags_t f,
   input  logic       tmr_done,
   output logic       tmr_start,
   output logic       tmr_clear,
   output logic [2:0] tmr_kind,
   output logic       base_chg,
   output logic       base_dsg,
   output logic       pwr_down
);
   cgc_state_e st, st_nx;
   cgc_kind_e  cand, pend;

   function automatic cgc_state_e fault_of(input cgc_kind_e k);
      case (k)
         K_OVC:                 return ST_OVCHG;
         K_OVD:                 return ST_OVDIS;
         K_OC1, K_OC2, K_SHORT: return ST_OVCUR;
         K_ABN:                 return ST_ABNCHG;
         default:               return ST_NORM;
      endcase
   endfunction

   // candidate fault, highest priority first
   always_comb begin
      cand = K_NONE;
      if (st == ST_NORM) begin
         if      (f.short_hi) cand = K_SHORT;
         else if (f.oc2_hi)   cand = K_OC2;
         else if (f.oc1_hi)   cand = K_OC1;
         else if (f.ovc_hi)   cand = K_OVC;
         else if (f.ovd_lo)   cand = K_OVD;
         else if (f.chg_seen) cand = K_ABN;
      end
   end

   always_comb begin
      st_nx = st;
      case (st)
         ST_NORM:
            if (tmr_done && cand != K_NONE && cand == pend) st_nx = fault_of(cand);
         ST_OVCHG:
            if ((f.ocrel_lo && !f.chg_seen) || (f.oc1_hi && !f.ovc_hi)) st_nx = ST_NORM;
         ST_OVDIS:
            if (f.chg_seen ? !f.ovd_lo : f.odrel_hi) st_nx = ST_NORM;
            else if (f.vm_small && !f.chg_seen)      st_nx = ST_PDOWN;
         ST_PDOWN:
            if (f.chg_seen) st_nx = ST_OVDIS;
         ST_OVCUR:
            if (!f.oc1_hi) st_nx = ST_NORM;
         ST_ABNCHG:
            if (!f.chg_seen) st_nx = ST_NORM;
         default: st_nx = ST_NORM;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_NORM;
         pend      <= K_NONE;
         tmr_start <= 1'b0;
         tmr_clear <= 1'b0;
         tmr_kind  <= K_NONE;
      end else begin
         st        <= st_nx;
         tmr_start <= 1'b0;
         tmr_clear <= 1'b0;
         if (st == ST_NORM && st_nx == ST_NORM) begin
            if (cand != pend) begin
               pend <= cand;
               if (cand != K_NONE) begin
                  tmr_start <= 1'b1;
                  tmr_kind  <= cand;
               end else begin
                  tmr_clear <= 1'b1;
               end
            end
         end else begin
            pend <= K_NONE;
         end
      end
   end

   assign base_chg = !(st == ST_OVCHG || st == ST_ABNCHG);
   assign base_dsg = (st == ST_NORM || st == ST_OVCHG || st == ST_ABNCHG);
   assign pwr_down = (st == ST_PDOWN);

   assert_ovchg_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_NORM && tmr_done && pend == K_OVC && cand == K_OVC) |=> st == ST_OVCHG);
   assert_charger_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_OVCHG && f.chg_seen && !(f.oc1_hi && !f.ovc_hi)) |=> st == ST_OVCHG);
   assert_pdown_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_OVDIS && f.vm_small && !f.chg_seen && !f.odrel_hi) |=> pwr_down);
   assert_ocur_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_OVCUR && !f.oc1_hi) |=> st == ST_NORM);
   assert_abn_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ABNCHG && !f.chg_seen) |=> base_chg);
   assert_tmr_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(tmr_start && tmr_clear));
endmodule

// File: rtl/cgc_zv.sv
module cgc_zv #(
   parameter bit ZV_CHARGE = 1'b0
) (
   input  logic base_chg,
   input  logic zv_lo,
   input  logic zv_start,
   output logic chg_en
);
   generate
      if (ZV_CHARGE) begin : g_zv_force
         logic unused_lo;
         assign unused_lo = zv_lo;
         assign chg_en    = base_chg | zv_start;
      end else begin : g_zv_inhibit
         logic unused_start;
         assign unused_start = zv_start;
         assign chg_en       = base_chg & ~zv_lo;
      end
   endgenerate
endmodule

// File: rtl/cell_guard_ctrl.sv
module cell_guard_ctrl
   import cgc_pkg::*;
#(
   parameter bit          ZV_CHARGE   = 1'b0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ovc_hi,
   input  logic       ocrel_lo,
   input  logic       ovd_lo,
   input  logic       odrel_hi,
   input  logic       chg_seen,
   input  logic       oc1_hi,
   input  logic       oc2_hi,
   input  logic       short_hi,
   input  logic       vm_small,
   input  logic       zv_lo,
   input  logic       zv_start,
   input  logic       tmr_done,
   output logic       tmr_start,
   output logic       tmr_clear,
   output logic [2:0] tmr_kind,
   output logic       chg_en,
   output logic       dsg_en,
   output logic       pwr_down
);
   cgc_flags_t raw, fs;
   logic [CGC_NFLAGS-1:0] fs_bits;
   logic base_chg;

   always_comb begin
      raw          = '0;
      raw.ovc_hi   = ovc_hi;
      raw.ocrel_lo = ocrel_lo;
      raw.ovd_lo   = ovd_lo;
      raw.odrel_hi = odrel_hi;
      raw.chg_seen = chg_seen;
      raw.oc1_hi   = oc1_hi;
      raw.oc2_hi   = oc2_hi;
      raw.short_hi = short_hi;
      raw.vm_small = vm_small;
      raw.zv_lo    = zv_lo;
      raw.zv_start = zv_start;
   end

   cgc_sync #(.W(CGC_NFLAGS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(fs_bits)
   );
   assign fs = cgc_flags_t'(fs_bits);

   cgc_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .f(fs), .tmr_done(tmr_done),
      .tmr_start(tmr_start), .tmr_clear(tmr_clear), .tmr_kind(tmr_kind),
      .base_chg(base_chg), .base_dsg(dsg_en), .pwr_down(pwr_down)
   );

   cgc_zv #(.ZV_CHARGE(ZV_CHARGE)) u_zv (
      .base_chg(base_chg), .zv_lo(fs.zv_lo), .zv_start(fs.zv_start), .chg_en(chg_en)
   );

   generate
      if (ZV_CHARGE) begin : g_chk_force
         assert_zv_force_R12: assert property (@(posedge clk) disable iff (!rst_n)
            fs.zv_start |-> chg_en);
      end else begin : g_chk_inhibit
         assert_zv_inhibit_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (fs.zv_lo && $past(fs.zv_lo)) |-> !chg_en);
      end
   endgenerate
endmodule

// File: tb/test_cell_guard_ctrl.sv
`timescale 1ns/1ps
module test_cell_guard_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ovc_hi = 0, ocrel_lo = 1, ovd_lo = 0, odrel_hi = 1, chg_seen = 0;
   logic oc1_hi = 0, oc2_hi = 0, short_hi = 0, vm_small = 0, zv_lo = 0, zv_start = 0;
   logic tmr_done = 0;
   logic tmr_start, tmr_clear, chg_en, dsg_en, pwr_down;
   logic [2:0] tmr_kind;
   logic b_start, b_clear, b_chg, b_dsg, b_pd;
   logic [2:0] b_kind;
   int n_chk = 0, n_fail = 0, n_clr = 0;
   logic [2:0] last_kind = 3'd0;
   int tcnt = 0;
   logic tact = 1'b0;

   always #2.5 clk = ~clk;

   cell_guard_ctrl #(.ZV_CHARGE(1'b0)) i_cell_guard_ctrl (
      .clk, .rst_n, .ovc_hi, .ocrel_lo, .ovd_lo, .odrel_hi, .chg_seen, .oc1_hi, .oc2_hi,
      .short_hi, .vm_small, .zv_lo, .zv_start, .tmr_done,
      .tmr_start, .tmr_clear, .tmr_kind, .chg_en, .dsg_en, .pwr_down);

   cell_guard_ctrl #(.ZV_CHARGE(1'b1)) i_cell_guard_ctrl_zv (
      .clk, .rst_n, .ovc_hi, .ocrel_lo, .ovd_lo, .odrel_hi, .chg_seen, .oc1_hi, .oc2_hi,
      .short_hi, .vm_small, .zv_lo, .zv_start, .tmr_done,
      .tmr_start(b_start), .tmr_clear(b_clear), .tmr_kind(b_kind),
      .chg_en(b_chg), .dsg_en(b_dsg), .pwr_down(b_pd));

   function automatic int delay_of(input logic [2:0] k);
      case (k)
         3'd1, 3'd6: return 40;
         3'd2:       return 30;
         3'd3:       return 20;
         3'd4:       return 10;
         3'd5:       return 3;
         default:    return 1;
      endcase
   endfunction

   function automatic logic exp_chg_inhibit(input logic z);
      return !z;
   endfunction

   // delay timer model
   always @(posedge clk) begin
      tmr_done <= 1'b0;
      if (tmr_clear) begin
         tact <= 1'b0;
         n_clr <= n_clr + 1;
      end else if (tmr_start) begin
         tact <= 1'b1;
         tcnt <= delay_of(tmr_kind);
         last_kind <= tmr_kind;
      end else if (tact) begin
         if (tcnt <= 1) begin
            tmr_done <= 1'b1;
            tact <= 1'b0;
         end else tcnt <= tcnt - 1;
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #1000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
   end

   initial begin
      int clr0;
      void'($urandom(32'd1234));
      cyc(3);
      rst_n = 1'b1;
      cyc(6);
      chk("R1 chg", chg_en, 1); chk("R1 dsg", dsg_en, 1); chk("R1 pd", pwr_down, 0);

      // overcharge
      ovc_hi = 1; ocrel_lo = 0;
      cyc(20); chk("R2 before delay", chg_en, 1);
      cyc(40); chk("R2 chg off", chg_en, 0); chk("R2 dsg on", dsg_en, 1);
      chk("R10 kind ovc", last_kind == 3'd1, 1);

      // charger holds overcharge
      ovc_hi = 0; ocrel_lo = 1; chg_seen = 1;
      cyc(10); chk("R4 held", chg_en, 0);
      chg_seen = 0;
      cyc(6); chk("R3 release hyst", chg_en, 1);

      // load release then overcurrent 1
      ovc_hi = 1; ocrel_lo = 0;
      cyc(55); chk("R2 again", chg_en, 0);
      ovc_hi = 0; oc1_hi = 1;
      cyc(6); chk("R3 load release", chg_en, 1);
      cyc(25); chk("R8 oc1 off", dsg_en, 0);
      oc1_hi = 0; ocrel_lo = 1;
      cyc(6); chk("R8 release", dsg_en, 1);

      // short has priority
      oc1_hi = 1; short_hi = 1;
      cyc(12); chk("R8 short fast", dsg_en, 0);
      chk("R8 short kind", last_kind == 3'd5, 1);
      oc1_hi = 0; short_hi = 0;
      cyc(6); chk("R8 short release", dsg_en, 1);

      // glitch cleared
      clr0 = n_clr;
      oc1_hi = 1; cyc(8); oc1_hi = 0;
      cyc(40); chk("R10 glitch ignored", dsg_en, 1);
      chk("R10 clear issued", n_clr > clr0, 1);

      // overdischarge, release without charger
      ovd_lo = 1; odrel_hi = 0;
      cyc(15); chk("R5 before delay", dsg_en, 1);
      cyc(30); chk("R5 dsg off", dsg_en, 0); chk("R5 chg on", chg_en, 1);
      ovd_lo = 0;
      cyc(10); chk("R7 needs hyst", dsg_en, 0);
      odrel_hi = 1;
      cyc(6); chk("R7 hyst release", dsg_en, 1);

      // power-down and charger release
      ovd_lo = 1; odrel_hi = 0;
      cyc(45); chk("R5 again", dsg_en, 0);
      vm_small = 1;
      cyc(6); chk("R6 pd enter", pwr_down, 1);
      chg_seen = 1;
      cyc(6); chk("R6 pd exit", pwr_down, 0); chk("R6 still off", dsg_en, 0);
      vm_small = 0; ovd_lo = 0;
      cyc(6); chk("R7 charger release", dsg_en, 1);

      // abnormal charge, zero-volt force
      cyc(55); chk("R9 chg off", chg_en, 0); chk("R9 dsg on", dsg_en, 1);
      chk("R12 no force", b_chg, 0);
      zv_start = 1;
      cyc(4); chk("R12 forced", b_chg, 1); chk("R11 start ignored", chg_en, 0);
      zv_start = 0; odrel_hi = 1; chg_seen = 0;
      cyc(6); chk("R9 release", chg_en, 1);

      // zero-volt inhibit latency
      zv_lo = 1;
      cyc(1); chk("R13 one edge", chg_en, 1);
      cyc(1); chk("R13 two edges", chg_en, 0);
      chk("R11 inhibit", chg_en, 0); chk("R12 lo ignored", b_chg, 1);
      zv_lo = 0;
      cyc(4); chk("R11 restore", chg_en, 1);

      // random: short overcurrent pulses and zero-volt toggles
      for (int i = 0; i < 20; i++) begin
         oc1_hi = 1; cyc(2 + ($urandom % 12));
         oc1_hi = 0; cyc(3 + ($urandom % 8));
         chk("R10 random pulse", dsg_en, 1);
      end
      for (int i = 0; i < 12; i++) begin
         logic z;
         z = 1'($urandom % 2);
         zv_lo = z;
         cyc(4); chk("R11 random", chg_en, exp_chg_inhibit(z));
      end
      zv_lo = 0;
      cyc(30); chk("R10 random end", dsg_en, 1);

      report();
      $finish;
   end
endmodule